// File: doc/BRIEF.md
# Pipelined ADC Digit Combiner

This block sits behind the analog stages of a pipelined 8-bit converter. Six residue stages each resolve a coarse 2-bit digit, and a final comparator resolves one last bit. Every stage works on a given sample one step later than the stage before it. The combiner first delays the earlier digits so that all digits of one sample line up in the same cycle. It then adds them with overlapping weights, so that a comparator decision error in one stage is absorbed by the digit of the next stage. Finally it clamps the result to the 8-bit code range.

The digital part is fully synchronous to the rising edge of `clk`. The stage-1 digit of a sample is taken at one edge, and the registered 8-bit code for that sample appears five edges later. This delay, together with the half-cycle of sampling in front of the block, gives the converter its total sample-to-output latency. The reset `rst_n` is asynchronous when asserted. It is expected to be released synchronously to `clk` by the reset network upstream of the block.

Top module: `adc_digit_combiner`

## Requirements
- R1: While `rst_n` is low, `code_out` is 0 and `code_vld` is 0, whatever the digit inputs are.
- R2: After reset is released, `code_vld` stays 0 through the first five rising edges. It goes to 1 after the sixth rising edge and then stays 1 until the next reset.
- R3: For one sample, the stage-k digit (k = 1..6) must be presented at edge n+k-1, where edge n is the edge that takes the stage-1 digit. The final bit must be presented at edge n+5, together with the stage-6 digit. The code for that sample is on `code_out` right after edge n+5.
- R4: The stage-k digit sits at bits [2k-1:2k-2] of `stg_dig` and is read as an unsigned value d_k from 0 to 3. The raw sum is 64*d1 + 32 + sum over k = 2..6 of (d_k - 1)*2^(7-k) + f, where f is `fin_bit`. When the raw sum is between 0 and 255, `code_out` equals it.
- R5: When the raw sum is negative, `code_out` is 0.
- R6: When the raw sum exceeds 255, `code_out` is 255.
- R7: Across the legal digit sets (d1 from 0 to 3, d2 to d6 from 0 to 2, f either value), every output code from 0 to 255 is produced by at least one set, so no code is missing.
- R8: Whenever `code_out` is valid and lies strictly between 0 and 255, its LSB equals the final bit of that sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock; all registers update on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| stg_dig | input | 12 | Six 2-bit stage digits, stage 1 in the lowest two bits, each arriving one cycle after the stage before it |
| fin_bit | input | 1 | Final comparator bit, arriving in the same cycle as the stage-6 digit |
| code_out | output | 8 | Corrected, clamped binary code |
| code_vld | output | 1 | High once the alignment registers have filled after reset |

## Verification
A sample's stage-1 digit is driven in cycle t, and each later digit is driven one cycle after the one before it. The corrected code for that sample is due after the fifth following edge. The bench therefore compares the sample driven six iterations earlier, at the falling edge, and drives the next digits only after that comparison. `code_vld` is compared at every iteration against the count of edges since reset release, which fixes the exact edge at which it must first rise. The sweep covers every legal digit combination, so the low clamp, the high clamp and the 256-code coverage check are all reached by exhaustive stimulus.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  // Default geometry: six residue stages of two-bit digits plus one flash bit.
  localparam int unsigned STAGES_DEF = 6;
  localparam int unsigned DIGW_DEF   = 2;

  // Output width follows from the stage count: stage one carries two bits,
  // each later stage and the flash bit one bit each.
  function automatic int unsigned code_width(input int unsigned stages);
    return stages + 2;
  endfunction

  // Number of alignment registers a given stage (0-based) needs.
  function automatic int unsigned skew_depth(input int unsigned stages,
                                             input int unsigned idx);
    return stages - 1 - idx;
  endfunction
endpackage

// File: rtl/adc_skew_line.sv
module adc_skew_line #(
  parameter int unsigned W     = 2,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] tap_q [DEPTH];
  logic [W-1:0] tap_d [DEPTH];

  always_comb begin
    tap_d[0] = din;
    for (int j = 1; j < DEPTH; j++) begin
      tap_d[j] = tap_q[j-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) tap_q[j] <= '0;
    end else begin
      for (int j = 0; j < DEPTH; j++) tap_q[j] <= tap_d[j];
    end
  end

  assign dout = tap_q[DEPTH-1];
endmodule

// File: rtl/adc_overlap_sum.sv
module adc_overlap_sum #(
  parameter int unsigned STAGES = 6,
  parameter int unsigned DIGW   = 2,
  parameter int unsigned OUTW   = STAGES + 2
) (
  input  logic [STAGES*DIGW-1:0] dig_al,
  input  logic                   fin_al,
  output logic [OUTW-1:0]        code
);
  localparam int unsigned SW = OUTW + 3;
  localparam logic signed [SW-1:0] MAXC = SW'((1 << OUTW) - 1);
  localparam logic signed [SW-1:0] BIAS = SW'(1 << (OUTW - 3));

  logic signed [SW-1:0] acc;
  logic        [SW-1:0] uext;

  always_comb begin
    uext = {{(SW-DIGW){1'b0}}, dig_al[DIGW-1:0]};
    acc  = BIAS + ($signed(uext) <<< (OUTW - 2));
    for (int i = 1; i < STAGES; i++) begin
      uext = {{(SW-DIGW){1'b0}}, dig_al[i*DIGW +: DIGW]};
      acc  = acc + (($signed(uext) - SW'(1)) <<< (OUTW - 2 - i));
    end
    acc = acc + $signed({{(SW-1){1'b0}}, fin_al});

    if (acc < 0) begin
      code = '0;
    end else if (acc > MAXC) begin
      code = '1;
    end else begin
      code = acc[OUTW-1:0];
    end
  end
endmodule

// File: rtl/adc_fill_track.sv
module adc_fill_track #(
  parameter int unsigned FILL = 5
) (
  input  logic clk,
  input  logic rst_n,
  output logic full
);
  localparam int unsigned CW = $clog2(FILL + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = (cnt_q != CW'(FILL));

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign full = !cnt_en;
endmodule

// File: rtl/adc_digit_combiner.sv
module adc_digit_combiner
  import adc_corr_pkg::*;
#(
  parameter int unsigned STAGES = STAGES_DEF,
  parameter int unsigned DIGW   = DIGW_DEF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [STAGES*DIGW-1:0]        stg_dig,
  input  logic                          fin_bit,
  output logic [code_width(STAGES)-1:0] code_out,
  output logic                          code_vld
);
  localparam int unsigned OUTW = code_width(STAGES);

  logic [STAGES*DIGW-1:0] dig_al;
  logic [OUTW-1:0]        code_d, code_q;
  logic                   vld_d, vld_q;
  logic                   pipe_full;

  // Earlier stages wait longer; the last stage passes straight through.
  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    localparam int unsigned DEP = skew_depth(STAGES, g);
    if (DEP == 0) begin : g_direct
      assign dig_al[g*DIGW +: DIGW] = stg_dig[g*DIGW +: DIGW];
    end else begin : g_delay
      adc_skew_line #(.W(DIGW), .DEPTH(DEP)) u_skew (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (stg_dig[g*DIGW +: DIGW]),
        .dout (dig_al[g*DIGW +: DIGW])
      );
    end
  end

  adc_overlap_sum #(.STAGES(STAGES), .DIGW(DIGW), .OUTW(OUTW)) u_sum (
    .dig_al(dig_al),
    .fin_al(fin_bit),
    .code  (code_d)
  );

  adc_fill_track #(.FILL(STAGES - 1)) u_fill (
    .clk  (clk),
    .rst_n(rst_n),
    .full (pipe_full)
  );

  always_comb begin
    vld_d = vld_q | pipe_full;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      vld_q  <= vld_d;
    end
  end

  assign code_out = code_q;
  assign code_vld = vld_q;
endmodule

// File: rtl/adc_digit_combiner_chk.sv
module adc_digit_combiner_chk #(
  parameter int unsigned STAGES = 6,
  parameter int unsigned OUTW   = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fin_bit,
  input logic [OUTW-1:0] code_out,
  input logic            code_vld
);
  localparam int unsigned FILLW = $clog2(STAGES + 1);

  logic [FILLW-1:0] edges_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edges_seen <= '0;
    else if (edges_seen != FILLW'(STAGES)) edges_seen <= edges_seen + FILLW'(1);
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (code_out == '0 && !code_vld));

  assert_fill_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld == (edges_seen == FILLW'(STAGES)));

  assert_vld_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    code_vld |=> code_vld);

  assert_lsb_flash_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && code_out != '0 && code_out != '1) |-> (code_out[0] == $past(fin_bit)));
endmodule

bind adc_digit_combiner adc_digit_combiner_chk #(.STAGES(STAGES), .OUTW(OUTW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .fin_bit (fin_bit),
  .code_out(code_out),
  .code_vld(code_vld)
);

// File: tb/sim_adc_digit_combiner.sv
module sim_adc_digit_combiner;
  localparam int NLEG = 4 * 243 * 2;
  localparam int NEXT = 8;
  localparam int NS   = NLEG + NEXT;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] stg_dig;
  logic        fin_bit;
  logic [7:0]  code_out;
  logic        code_vld;

  int sd [NS][6];
  int sf [NS];
  bit hit [256];
  int n_chk = 0;
  int n_err = 0;
  int n_lo  = 0;
  int n_hi  = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  adc_digit_combiner u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .stg_dig (stg_dig),
    .fin_bit (fin_bit),
    .code_out(code_out),
    .code_vld(code_vld)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  function automatic int raw_of(input int n);
    int r;
    r = 64 * sd[n][0] + 32;
    for (int k = 1; k < 6; k++) r += (sd[n][k] - 1) * (1 << (6 - k));
    return r + sf[n];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    wrap_up();
  end

  initial begin
    // Build the sample table: every legal digit set, then a few with code 3.
    for (int i = 0; i < NLEG; i++) begin
      int rem;
      rem   = i;
      sf[i] = rem % 2; rem = rem / 2;
      for (int k = 5; k >= 1; k--) begin
        sd[i][k] = rem % 3; rem = rem / 3;
      end
      sd[i][0] = rem % 4;
    end
    for (int j = 0; j < NEXT; j++) begin
      sd[NLEG+j][0] = j % 4;
      for (int k = 1; k < 6; k++) sd[NLEG+j][k] = 3;
      sf[NLEG+j] = j / 4;
    end

    rst_n   = 1'b0;
    stg_dig = 12'hAAA;
    fin_bit = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs quiet during reset despite active inputs
    chk(code_out == 8'd0, "R1 code", code_out, 0);
    chk(code_vld == 1'b0, "R1 vld", code_vld, 0);

    rst_n = 1'b1;
    for (int t = 0; t <= NS + 5; t++) begin
      if (t > 0) @(negedge clk);
      // R2: valid rises only after the sixth edge since release
      chk(code_vld == (t >= 6), "R2 vld", code_vld, (t >= 6));
      if (t >= 6) begin
        int n, r, e;
        string tag;
        n = t - 6;
        r = raw_of(n);
        e = (r < 0) ? 0 : (r > 255) ? 255 : r;
        tag = (r < 0) ? "R5 low clamp" : (r > 255) ? "R6 high clamp" : "R4 R3 sum";
        if (r < 0) n_lo++;
        if (r > 255) n_hi++;
        chk(code_out == 8'(e), tag, code_out, e);
        if (e != 0 && e != 255)
          chk(code_out[0] == sf[n][0], "R8 lsb", code_out[0], sf[n]);
        if (n < NLEG) hit[code_out] = 1'b1;
      end
      for (int k = 0; k < 6; k++) begin
        int m;
        m = t - k;
        stg_dig[2*k +: 2] = (m >= 0 && m < NS) ? 2'(sd[m][k]) : 2'd0;
      end
      fin_bit = (t - 5 >= 0 && t - 5 < NS) ? sf[t-5][0] : 1'b0;
    end

    begin
      int miss;
      miss = 0;
      for (int c = 0; c < 256; c++) if (!hit[c]) miss++;
      chk(miss == 0, "R7 missing codes", miss, 0);
    end
    chk(n_lo > 0, "R5 low clamp reached", n_lo, 1);
    chk(n_hi > 0, "R6 high clamp reached", n_hi, 1);
    wrap_up();
  end
endmodule